// File: doc/BRIEF.md
# Vector-Length Loop Control Unit

This unit keeps the two registers that steer a strip-mined vector loop: a 64-bit remaining-element counter and a vector-length register that says how many elements the current pass handles. Software loads the element count into the counter once, before the loop. At the head of each pass it issues a set-length command, which picks the lesser of a requested maximum and the remaining count. At the foot of each pass it issues a branch command, which removes the whole batch from the counter in one step and reports whether another pass is needed.

The counter drops by the batch size, not by one. The batch size is never larger than what remains, so the counter lands on exactly zero after the last element. On the final pass the batch shrinks to the leftover elements. The unit takes one command per clock. The counter, the vector length and the taken flag show the effect of a command on the cycle after it is accepted.

Top module: `vl_loop_ctrl`

## Requirements
- R1: After synchronous reset the counter output is 0, the vector-length output is 0 and the taken flag is 0.
- R2: A valid command with opcode 2'b01 (load) copies the 64-bit operand into the counter on the next cycle and leaves the vector length unchanged.
- R3: A valid command with opcode 2'b10 (set-length) forms a maximum equal to the operand, capped at VL_LIMIT (32 by default). The vector length becomes the lesser of that maximum and the counter, and the counter does not change.
- R4: When the counter is below the requested maximum, set-length makes the vector length equal to the counter, so the last pass covers only the leftover elements.
- R5: A valid command with opcode 2'b11 (branch) subtracts the vector length from the counter. It sets the taken flag to 1 when the result is nonzero and to 0 when the result is zero.
- R6: If a branch finds the vector length larger than the counter, the counter becomes 0 instead of wrapping, and the branch is not taken.
- R7: With the counter at 0, set-length gives a vector length of 0. A branch that follows leaves the counter at 0 and is not taken.
- R8: A cycle with cmd_valid low, or with opcode 2'b00, leaves the counter and the vector length unchanged.
- R9: The taken flag is 1 only in the cycle after a valid branch command. Any other cycle clears it.
- R10: A loop of one load and then repeated set-length and branch pairs ends after exactly ceil(n / maximum) taken-or-final branches, with the counter at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode: 00 none, 01 load, 10 set-length, 11 branch |
| cmd_operand | input | 64 | Element count for load, requested maximum for set-length |
| vl_o | output | 6 | Current vector length |
| ctr_o | output | 64 | Remaining element counter |
| taken_o | output | 1 | Branch taken flag |

## Verification
Every result sits exactly one register stage behind the command that causes it. The counter, the vector length and the taken flag all change at the first rising edge that samples the valid command. The bench drives a command on a falling edge and drops cmd_valid on the next falling edge. It then reads all three outputs at that falling edge, half a cycle after the edge that loaded them. Idle cycles are checked the same way, one falling edge after they are applied, to show that nothing moved and that the taken flag fell.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    localparam int DEF_CTR_W    = 64;
    localparam int DEF_VL_W     = 6;
    localparam int DEF_VL_LIMIT = 32;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_LOAD   = 2'b01,
        OP_SETLEN = 2'b10,
        OP_BRANCH = 2'b11
    } op_e;

    typedef struct packed {
        logic load;
        logic setlen;
        logic branch;
    } dec_t;

    function automatic dec_t decode_cmd(logic valid, logic [1:0] op);
        dec_t d;
        d.load   = valid && (op == OP_LOAD);
        d.setlen = valid && (op == OP_SETLEN);
        d.branch = valid && (op == OP_BRANCH);
        return d;
    endfunction

endpackage

// File: rtl/vlc_decode.sv
module vlc_decode
    import vlc_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output dec_t       dec
);
    always_comb begin
        dec = decode_cmd(cmd_valid, cmd_op);
    end
endmodule

// File: rtl/vlc_len_calc.sv
module vlc_len_calc #(
    parameter int CTR_W    = 64,
    parameter int VL_W     = 6,
    parameter int VL_LIMIT = 32
) (
    input  logic [CTR_W-1:0] req_max,
    input  logic [CTR_W-1:0] ctr,
    output logic [VL_W-1:0]  vl_new
);
    localparam logic [CTR_W-1:0] LIMIT_EXT = CTR_W'(VL_LIMIT);

    logic [CTR_W-1:0] cap;

    always_comb begin
        cap    = (req_max > LIMIT_EXT) ? LIMIT_EXT : req_max;
        vl_new = (ctr < cap) ? VL_W'(ctr) : VL_W'(cap);
    end
endmodule

// File: rtl/vlc_ctr_step.sv
module vlc_ctr_step #(
    parameter int CTR_W = 64,
    parameter int VL_W  = 6
) (
    input  logic [CTR_W-1:0] ctr,
    input  logic [VL_W-1:0]  vl,
    output logic [CTR_W-1:0] ctr_next,
    output logic             taken_next
);
    logic [CTR_W-1:0] vl_ext;

    always_comb begin
        vl_ext     = {{(CTR_W-VL_W){1'b0}}, vl};
        ctr_next   = (vl_ext > ctr) ? '0 : (ctr - vl_ext);
        taken_next = (ctr_next != '0);
    end
endmodule

// File: rtl/vl_loop_ctrl.sv
module vl_loop_ctrl
    import vlc_pkg::*;
#(
    parameter int CTR_W    = DEF_CTR_W,
    parameter int VL_W     = DEF_VL_W,
    parameter int VL_LIMIT = DEF_VL_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [CTR_W-1:0] cmd_operand,
    output logic [VL_W-1:0]  vl_o,
    output logic [CTR_W-1:0] ctr_o,
    output logic             taken_o
);
    dec_t             dec;
    logic [VL_W-1:0]  vl_q, vl_calc;
    logic [CTR_W-1:0] ctr_q, ctr_dec;
    logic             taken_q, taken_calc;

    vlc_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .dec       (dec)
    );

    vlc_len_calc #(.CTR_W(CTR_W), .VL_W(VL_W), .VL_LIMIT(VL_LIMIT)) u_len (
        .req_max (cmd_operand),
        .ctr     (ctr_q),
        .vl_new  (vl_calc)
    );

    vlc_ctr_step #(.CTR_W(CTR_W), .VL_W(VL_W)) u_step (
        .ctr        (ctr_q),
        .vl         (vl_q),
        .ctr_next   (ctr_dec),
        .taken_next (taken_calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q   <= '0;
            vl_q    <= '0;
            taken_q <= 1'b0;
        end else begin
            taken_q <= 1'b0;
            if (dec.load) begin
                ctr_q <= cmd_operand;
            end else if (dec.setlen) begin
                vl_q <= vl_calc;
            end else if (dec.branch) begin
                ctr_q   <= ctr_dec;
                taken_q <= taken_calc;
            end
        end
    end

    assign vl_o    = vl_q;
    assign ctr_o   = ctr_q;
    assign taken_o = taken_q;
endmodule

// File: rtl/vl_loop_ctrl_chk.sv
module vl_loop_ctrl_chk #(
    parameter int CTR_W    = 64,
    parameter int VL_W     = 6,
    parameter int VL_LIMIT = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [CTR_W-1:0] cmd_operand,
    input logic [VL_W-1:0]  vl_o,
    input logic [CTR_W-1:0] ctr_o,
    input logic             taken_o
);
    p_load_copies_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b01) |=> (ctr_o == $past(cmd_operand)));

    p_len_capped_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10) |=> (int'(vl_o) <= VL_LIMIT));

    p_len_within_ctr_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10) |=> ({{(CTR_W-VL_W){1'b0}}, vl_o} <= ctr_o));

    p_taken_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> (ctr_o != '0));

    p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b11) |=> (ctr_o <= $past(ctr_o)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || cmd_op == 2'b00) |=> ($stable(ctr_o) && $stable(vl_o)));

    p_taken_only_branch_r9: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_op == 2'b11) |=> !taken_o);
endmodule

bind vl_loop_ctrl vl_loop_ctrl_chk #(
    .CTR_W(CTR_W), .VL_W(VL_W), .VL_LIMIT(VL_LIMIT)
) chk_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_operand(cmd_operand), .vl_o(vl_o), .ctr_o(ctr_o), .taken_o(taken_o)
);

// File: tb/vl_loop_ctrl_tb_top.sv
`timescale 1ns/1ps
module vl_loop_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [63:0] cmd_operand;
    logic [5:0]  vl_o;
    logic [63:0] ctr_o;
    logic        taken_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    vl_loop_ctrl dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_operand(cmd_operand), .vl_o(vl_o), .ctr_o(ctr_o), .taken_o(taken_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_all(input string req, input logic [63:0] c, input logic [5:0] v, input logic t);
        check(ctr_o == c, {req, " ctr"}, ctr_o, c);
        check(vl_o == v, {req, " vl"}, 64'(vl_o), 64'(v));
        check(taken_o == t, {req, " taken"}, 64'(taken_o), 64'(t));
    endtask

    // Drive at falling edge; outputs are read at the next falling edge.
    task automatic issue(input logic [1:0] op, input logic [63:0] opnd);
        cmd_valid   = 1'b1;
        cmd_op      = op;
        cmd_operand = opnd;
        @(negedge clk);
        cmd_valid   = 1'b0;
        cmd_op      = 2'b00;
    endtask

    task automatic idle_cycle();
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        expect_all("R1", 64'd0, 6'd0, 1'b0);
    endtask

    task automatic t_load();
        issue(2'b01, 64'd100);
        expect_all("R2", 64'd100, 6'd0, 1'b0);
    endtask

    task automatic t_setlen_full();
        issue(2'b10, 64'd32);
        expect_all("R3", 64'd100, 6'd32, 1'b0);
        issue(2'b10, 64'd1000);           // cap at 32
        expect_all("R3 cap", 64'd100, 6'd32, 1'b0);
        issue(2'b10, 64'd7);
        expect_all("R3 small", 64'd100, 6'd7, 1'b0);
    endtask

    task automatic t_branch();
        issue(2'b11, 64'd0);              // 100-7
        expect_all("R5 taken", 64'd93, 6'd7, 1'b1);
        idle_cycle();
        expect_all("R9 clear", 64'd93, 6'd7, 1'b0);
    endtask

    task automatic t_partial();
        issue(2'b01, 64'd5);
        issue(2'b10, 64'd32);
        expect_all("R4", 64'd5, 6'd5, 1'b0);
        issue(2'b11, 64'd0);
        expect_all("R5 final", 64'd0, 6'd5, 1'b0);
    endtask

    task automatic t_saturate();
        issue(2'b01, 64'd20);
        issue(2'b10, 64'd32);
        issue(2'b01, 64'd3);              // VL 20 > CTR 3
        issue(2'b11, 64'd0);
        expect_all("R6", 64'd0, 6'd20, 1'b0);
    endtask

    task automatic t_zero();
        issue(2'b10, 64'd32);
        expect_all("R7 vl", 64'd0, 6'd0, 1'b0);
        issue(2'b11, 64'd0);
        expect_all("R7 branch", 64'd0, 6'd0, 1'b0);
    endtask

    task automatic t_idle();
        issue(2'b01, 64'd50);
        issue(2'b10, 64'd16);
        issue(2'b11, 64'd0);
        expect_all("R8 pre", 64'd34, 6'd16, 1'b1);
        cmd_valid = 1'b0; cmd_op = 2'b01; cmd_operand = 64'd999;
        @(negedge clk);
        expect_all("R8 invalid", 64'd34, 6'd16, 1'b0);
        issue(2'b00, 64'd7);
        expect_all("R8 op00", 64'd34, 6'd16, 1'b0);
    endtask

    task automatic t_loop(input logic [63:0] n, input logic [63:0] mx);
        logic [63:0] rem = n;
        int iters = 0;
        logic [63:0] want = (n + mx - 1) / mx;
        logic [5:0] ev;
        issue(2'b01, n);
        for (int k = 0; k < 200; k++) begin
            issue(2'b10, mx);
            ev = (rem < mx) ? rem[5:0] : mx[5:0];
            check(vl_o == ev, "R10 vl", 64'(vl_o), 64'(ev));
            issue(2'b11, 64'd0);
            rem = rem - 64'(ev);
            iters++;
            check(taken_o == (rem != 0), "R10 taken", 64'(taken_o), 64'(rem != 0));
            if (!taken_o) break;
        end
        check(ctr_o == 0, "R10 end ctr", ctr_o, 64'd0);
        check(64'(iters) == want, "R10 passes", 64'(iters), want);
    endtask

    initial begin
        cmd_valid = 1'b0; cmd_op = 2'b00; cmd_operand = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load();
        t_setlen_full();
        t_branch();
        t_partial();
        t_saturate();
        t_zero();
        t_idle();
        t_loop(64'd70, 64'd32);
        t_loop(64'd64, 64'd32);
        t_loop(64'd1, 64'd32);
        t_loop(64'd45, 64'd9);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule